// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block watches the two request streams of a shared two-port memory, called left and right. Each port presents an active-low select, an active-low write strobe and a word address. When both ports are selected and name the same word, the arbiter lets one access proceed. It pulls the busy line of the other port low. It also gives each port an internal write-go signal that the memory array uses in place of the raw strobe. A port that has lost contention therefore cannot write, whatever happens to its busy line outside the block.

The block runs on one clock, and arrival order is judged by cycle. Each port counts as "fresh" in a cycle where it has just become selected or has just changed its address. In any other cycle where it is selected, it counts as settled. When a match starts, the fresh port loses to a settled one. When both ports are fresh in the same cycle, a fixed tie-break set by a parameter decides. The decision is kept until the match ends, so a winner that flips its write strobe cannot pass the grant to the other side. A combined clash output flags any contention. It can be used as an error or interrupt source.

Busy, write-go and clash are combinational from the current inputs and the registered history. A match therefore shows in the same cycle in which the inputs present it.

Top module: `dpa_arbiter`

## Requirements
- R1: While either select is high, or the two addresses differ, both busy outputs are high, clash is low, and each port's write-go follows its own request (select low and write strobe low).
- R2: When a match begins while one port is settled (selected, with the same address as in the previous cycle) and the other is fresh (newly selected, or a changed address), the fresh port's busy goes low in that same cycle and the settled port's busy stays high.
- R3: When both ports are fresh in the cycle a match begins, the right port gets busy if TIE_GRANT_LEFT is 1 (the default), and the left port gets busy if it is 0.
- R4: The two busy outputs are never low at the same time.
- R5: While the match lasts, the busy side stays the same, even if the winner toggles its write strobe or the loser changes its own strobe.
- R6: A port's write-go is high exactly when its select is low, its write strobe is low and its own busy is high. A write from the busy port never reaches write-go.
- R7: Busy is released (high) in the first cycle where the addresses differ or either select goes high.
- R8: Clash is high exactly when one of the busy outputs is low.
- R9: While reset is held with both ports deselected, both busy outputs are high and clash is low. The first request after reset counts as fresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the history registers |
| l_sel_n | input | 1 | Left port select, active low |
| l_wr_n | input | 1 | Left port write strobe, active low |
| l_addr | input | ADDR_W | Left port word address |
| r_sel_n | input | 1 | Right port select, active low |
| r_wr_n | input | 1 | Right port write strobe, active low |
| r_addr | input | ADDR_W | Right port word address |
| l_busy_n | output | 1 | Left busy, active low, always driven |
| r_busy_n | output | 1 | Right busy, active low, always driven |
| l_wr_go | output | 1 | Gated write enable for the left port |
| r_wr_go | output | 1 | Gated write enable for the right port |
| clash | output | 1 | High while either port is held busy |

## Verification
The embedded properties assume that select, write strobe and address are known, non-X values at every clock edge once reset is released. They also assume that the ports are deselected while reset is held, so that the one-cycle history checks start from an idle state. The stimulus meets these assumptions. It changes the inputs only on the falling clock edge, always with defined values. Every scenario starts with an idle cycle in which both ports are deselected, so the freshness of each port in the next cycle is known exactly.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
   localparam int unsigned NUM_PORTS = 2;
   typedef enum logic {SIDE_LEFT = 1'b0, SIDE_RIGHT = 1'b1} side_e;
   localparam int unsigned LEFT_IDX  = 0;
   localparam int unsigned RIGHT_IDX = 1;
endpackage

// File: rtl/dpa_port_track.sv
module dpa_port_track #(
   parameter int unsigned ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [ADDR_W-1:0] addr,
   output logic              fresh
);
   logic              prev_en_q;
   logic [ADDR_W-1:0] prev_addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_en_q   <= 1'b0;
         prev_addr_q <= '0;
      end else begin
         prev_en_q   <= en;
         prev_addr_q <= addr;
      end
   end

   always_comb fresh = en && (!prev_en_q || (addr != prev_addr_q));

   // R2
   fresh_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fresh |-> en);
   // R9
   settled_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && $stable(addr) && $past(rst_n)) |-> !fresh);
endmodule

// File: rtl/dpa_loser_pick.sv
module dpa_loser_pick #(
   parameter int unsigned ADDR_W         = 10,
   parameter bit          TIE_GRANT_LEFT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        en,
   input  logic [ADDR_W-1:0] addr_l,
   input  logic [ADDR_W-1:0] addr_r,
   input  logic [1:0]        fresh,
   output logic              match,
   output logic [1:0]        lose
);
   import dpa_pkg::*;

   logic [1:0] tie_lose;
   logic       held_q;
   logic [1:0] lose_q;

   generate
      if (TIE_GRANT_LEFT) begin : g_tie_left
         assign tie_lose = 2'b10;
      end else begin : g_tie_right
         assign tie_lose = 2'b01;
      end
   endgenerate

   always_comb begin
      match = en[LEFT_IDX] && en[RIGHT_IDX] && (addr_l == addr_r);
      if (!match)             lose = 2'b00;
      else if (held_q)        lose = lose_q;
      else if (fresh == 2'b01) lose = 2'b01;
      else if (fresh == 2'b10) lose = 2'b10;
      else                    lose = tie_lose;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         lose_q <= 2'b00;
      end else begin
         held_q <= match;
         lose_q <= lose;
      end
   end

   // R4
   one_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lose));
   // R5
   keep_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match && $past(match) && $past(lose[0]) && $past(rst_n)) |-> lose[0]);
   // R5
   keep_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match && $past(match) && $past(lose[1]) && $past(rst_n)) |-> lose[1]);
   // R2
   late_side_loses_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match && !$past(match) && fresh == 2'b01) |-> lose[0]);
endmodule

// File: rtl/dpa_wr_gate.sv
module dpa_wr_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic wr_n,
   input  logic busy,
   output logic go
);
   always_comb go = en && !wr_n && !busy;

   // R6
   busy_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !go);
   // R6
   free_write_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !wr_n && !busy) |-> go);
endmodule

// File: rtl/dpa_arbiter.sv
module dpa_arbiter #(
   parameter int unsigned ADDR_W         = 10,
   parameter bit          TIE_GRANT_LEFT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_sel_n,
   input  logic              l_wr_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              r_sel_n,
   input  logic              r_wr_n,
   input  logic [ADDR_W-1:0] r_addr,
   output logic              l_busy_n,
   output logic              r_busy_n,
   output logic              l_wr_go,
   output logic              r_wr_go,
   output logic              clash
);
   import dpa_pkg::*;

   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_width
         $error("dpa_arbiter: ADDR_W must lie in 1..32");
      end
   endgenerate

   logic [NUM_PORTS-1:0]             en_v;
   logic [NUM_PORTS-1:0]             wr_n_v;
   logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_v;
   logic [NUM_PORTS-1:0]             fresh_v;
   logic [NUM_PORTS-1:0]             lose_v;
   logic [NUM_PORTS-1:0]             go_v;
   logic                             match;

   always_comb begin
      en_v[LEFT_IDX]    = !l_sel_n;
      en_v[RIGHT_IDX]   = !r_sel_n;
      wr_n_v[LEFT_IDX]  = l_wr_n;
      wr_n_v[RIGHT_IDX] = r_wr_n;
      addr_v[LEFT_IDX]  = l_addr;
      addr_v[RIGHT_IDX] = r_addr;
   end

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         dpa_port_track #(.ADDR_W(ADDR_W)) track_i (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_v[p]),
            .addr  (addr_v[p]),
            .fresh (fresh_v[p])
         );
         dpa_wr_gate gate_i (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_v[p]),
            .wr_n  (wr_n_v[p]),
            .busy  (lose_v[p]),
            .go    (go_v[p])
         );
      end
   endgenerate

   dpa_loser_pick #(.ADDR_W(ADDR_W), .TIE_GRANT_LEFT(TIE_GRANT_LEFT)) pick_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en_v),
      .addr_l (addr_v[LEFT_IDX]),
      .addr_r (addr_v[RIGHT_IDX]),
      .fresh  (fresh_v),
      .match  (match),
      .lose   (lose_v)
   );

   always_comb begin
      l_busy_n = !lose_v[LEFT_IDX];
      r_busy_n = !lose_v[RIGHT_IDX];
      l_wr_go  = go_v[LEFT_IDX];
      r_wr_go  = go_v[RIGHT_IDX];
      clash    = |lose_v;
   end

   // R1
   no_match_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l_sel_n || r_sel_n || (l_addr != r_addr)) |-> (l_busy_n && r_busy_n && !clash));
   // R4
   never_both_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!l_busy_n && !r_busy_n));
   // R7
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(match) && !match && $past(rst_n)) |-> (l_busy_n && r_busy_n));
   // R8
   clash_means_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clash |-> (!l_sel_n && !r_sel_n && (l_addr == r_addr)));
   // R3
   match_has_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match |-> $countones({l_busy_n, r_busy_n}) == 1);
endmodule

// File: tb/dpa_arbiter_tb_top.sv
module dpa_arbiter_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       l_sel_n = 1'b1, l_wr_n = 1'b1, r_sel_n = 1'b1, r_wr_n = 1'b1;
   logic [9:0] l_addr = '0, r_addr = '0;
   logic       l_busy_n, r_busy_n, l_wr_go, r_wr_go, clash;
   logic       a_l_busy_n, a_r_busy_n, a_l_wr_go, a_r_wr_go, a_clash;
   int         tests = 0;
   int         fails = 0;

   always #4 clk = ~clk;

   dpa_arbiter #(.ADDR_W(10), .TIE_GRANT_LEFT(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .l_sel_n(l_sel_n), .l_wr_n(l_wr_n), .l_addr(l_addr),
      .r_sel_n(r_sel_n), .r_wr_n(r_wr_n), .r_addr(r_addr),
      .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
      .l_wr_go(l_wr_go), .r_wr_go(r_wr_go), .clash(clash));

   dpa_arbiter #(.ADDR_W(10), .TIE_GRANT_LEFT(1'b0)) dut_alt_i (
      .clk(clk), .rst_n(rst_n),
      .l_sel_n(l_sel_n), .l_wr_n(l_wr_n), .l_addr(l_addr),
      .r_sel_n(r_sel_n), .r_wr_n(r_wr_n), .r_addr(r_addr),
      .l_busy_n(a_l_busy_n), .r_busy_n(a_r_busy_n),
      .l_wr_go(a_l_wr_go), .r_wr_go(a_r_wr_go), .clash(a_clash));

   // packed view: {l_busy_n, r_busy_n, l_wr_go, r_wr_go, clash}
   task automatic chk(input string req, input logic [4:0] exp);
      logic [4:0] act;
      act = {l_busy_n, r_busy_n, l_wr_go, r_wr_go, clash};
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%b exp=%b", req, act, exp);
      end
   endtask

   task automatic chk_alt(input string req, input logic [4:0] exp);
      logic [4:0] act;
      act = {a_l_busy_n, a_r_busy_n, a_l_wr_go, a_r_wr_go, a_clash};
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%b exp=%b", req, act, exp);
      end
   endtask

   // drive on falling edge, settle 3 ns, sample before next rising edge
   task automatic drive(input logic ls, input logic lw, input logic [9:0] la,
                        input logic rs, input logic rw, input logic [9:0] ra);
      @(negedge clk);
      l_sel_n = ls; l_wr_n = lw; l_addr = la;
      r_sel_n = rs; r_wr_n = rw; r_addr = ra;
      #3;
   endtask

   task automatic idle();
      drive(1, 1, 10'h000, 1, 1, 10'h000);
   endtask

   task automatic t_reset();
      #3;
      chk("R9 reset idle", 5'b11000);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle();
      chk("R9 idle after reset", 5'b11000);
   endtask

   task automatic t_no_match();
      idle();
      drive(0, 0, 10'h005, 0, 0, 10'h006);
      chk("R1 diff addr both write", 5'b11110);
      drive(1, 0, 10'h006, 0, 0, 10'h006);
      chk("R1 left deselected same addr", 5'b11010);
      drive(0, 1, 10'h006, 1, 0, 10'h006);
      chk("R1 right deselected same addr", 5'b11000);
   endtask

   task automatic t_right_late();
      idle();
      drive(0, 1, 10'h005, 1, 1, 10'h000);
      chk("R1 left alone read", 5'b11000);
      drive(0, 1, 10'h005, 0, 0, 10'h005);
      chk("R2 right arrives late", 5'b10001);
      drive(0, 0, 10'h005, 0, 0, 10'h005);
      chk("R5 R6 winner turns write, loser blocked", 5'b10101);
      drive(0, 0, 10'h005, 0, 0, 10'h006);
      chk("R7 release on address change", 5'b11110);
   endtask

   task automatic t_left_late();
      idle();
      drive(1, 1, 10'h000, 0, 0, 10'h3FF);
      chk("R6 right lone write", 5'b11010);
      drive(0, 0, 10'h3FF, 0, 0, 10'h3FF);
      chk("R2 R6 left arrives late, write blocked", 5'b01011);
      drive(0, 0, 10'h3FF, 0, 1, 10'h3FF);
      chk("R5 winner toggles strobe", 5'b01001);
      drive(1, 0, 10'h3FF, 0, 1, 10'h3FF);
      chk("R7 release on deselect", 5'b11000);
   endtask

   task automatic t_move_in();
      idle();
      drive(0, 0, 10'h010, 0, 0, 10'h020);
      chk("R1 both writing apart", 5'b11110);
      drive(0, 0, 10'h020, 0, 0, 10'h020);
      chk("R2 left moves onto right", 5'b01011);
      drive(0, 0, 10'h020, 0, 0, 10'h020);
      chk("R5 held next cycle", 5'b01011);
   endtask

   task automatic t_tie();
      idle();
      drive(0, 0, 10'h155, 0, 0, 10'h155);
      chk("R3 tie default right busy", 5'b10101);
      chk_alt("R3 tie alt left busy", 5'b01011);
      drive(0, 1, 10'h155, 0, 0, 10'h155);
      chk("R5 held after tie, winner reads", 5'b10001);
      drive(0, 1, 10'h155, 0, 1, 10'h155);
      chk("R5 loser changes strobe", 5'b10001);
      drive(0, 0, 10'h0AA, 0, 0, 10'h033);
      chk("R7 R8 both leave", 5'b11110);
      drive(0, 0, 10'h200, 0, 0, 10'h200);
      chk("R3 both move in same cycle", 5'b10101);
      chk("R8 clash while busy", {l_busy_n, r_busy_n, l_wr_go, r_wr_go, 1'b1});
      idle();
      chk("R8 clash clears", 5'b11000);
   endtask

   initial begin
      #(8 * 20000);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_no_match();
      t_right_late();
      t_left_late();
      t_move_in();
      t_tie();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule